// File: doc/BRIEF.md
# Byte-Level I2C Slave Transmit Engine with Clock Stretching

This block is the transmit half of an I2C slave. Address matching happens elsewhere. When that logic has accepted a read request, it pulses `arm`. The engine then holds SCL low until the host writes the first byte. Writing the byte is the release: the byte goes onto SDA most significant bit first, SDA changes only while SCL is low, and the engine lets go of SDA for the acknowledge slot.

At the rising edge of the ninth clock the engine records whether the master acknowledged. At the falling edge of the ninth clock it stretches SCL again and raises an end-of-transfer interrupt. After an acknowledge, the next host write sends the next byte. After a not-acknowledge, the engine stops driving data and ignores further writes. Only a release strobe frees SCL, so the master can finish with a stop.

A stop seen on the bus raises its own interrupt cause. A start seen in the middle of a transfer drops the engine out of transmit mode. Both bus lines are sampled through synchronizers in the system clock domain. Both outputs are open-drain pull-down enables.

Top module: `i2cst_top`

## Requirements
- R1: After `arm` in the idle state the engine holds SCL low (`scl_oe`=1) and leaves SDA released until a data write arrives.
- R2: A `tx_wr` while stretching loads `tx_data`, holds SCL for SETUP_CYC more cycles with the MSB on SDA, then releases SCL. During the high phase of clock k (k=1..8), SDA carries bit `tx_data[8-k]`.
- R3: The engine changes its SDA drive only while SCL is low, so SDA is stable throughout every SCL high phase of a data bit.
- R4: After the falling edge of the eighth clock the engine releases SDA (`sda_oe`=0) for the ninth clock.
- R5: At the rising edge of the ninth clock `ack_seen` takes the value 1 if SDA is low (ACK) and 0 if SDA is high (NACK).
- R6: At the falling edge of the ninth clock the engine holds SCL low and sets `irq_cause` to 2'b01 (end of transfer), with `irq`=1.
- R7: After a NACK the engine drives no data, and a `tx_wr` has no effect: SCL stays held and SDA stays released.
- R8: After a NACK, `rel_stb` releases SCL without sending data. While waiting for a data write after an ACK or `arm`, `rel_stb` has no effect and SCL stays held.
- R9: SDA rising while SCL is high is a stop. It sets `irq_cause` to 2'b10 and returns the engine to idle, with both lines released.
- R10: `irq` is high exactly when `irq_cause` is nonzero. `irq_ack` clears the cause to 2'b00 unless a new event arrives in the same cycle. A stop takes precedence over end of transfer.
- R11: SDA falling while SCL is high (a start) in the middle of a byte ends transmit mode. Both lines are released, no interrupt is raised, and later SCL clocks are not answered with data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level observed on the bus |
| sda_i | input | 1 | SDA level observed on the bus |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| arm | input | 1 | Enter transmit mode (address already matched) |
| tx_wr | input | 1 | Data write strobe; releases the stretch |
| tx_data | input | DATA_W | Byte to transmit |
| rel_stb | input | 1 | Release strobe used after a NACK |
| irq_ack | input | 1 | Clears the interrupt cause |
| ack_seen | output | 1 | Master acknowledge captured on the ninth clock |
| irq | output | 1 | Interrupt pending |
| irq_cause | output | 2 | 01 end of transfer, 10 stop detected |

## Verification
The bench builds the engine with SYNC_STAGES=3 and SETUP_CYC=6 instead of the defaults of 2 and 4. The deeper synchronizer stretches the delay between a bus edge and the engine's reaction, which exercises the rule that SDA moves only inside the SCL low phase. The longer setup hold makes the stretch after a write visible at the bus. The bench keeps DATA_W=8. Every byte, bit position, acknowledge choice and write delay is reached through random transactions ending in NACK and stop, plus a directed start in the middle of a byte.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_ACK   = 3'd4,
    ST_NACKW = 3'd5
  } tx_state_e;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_EOT  = 2'b01;
  localparam logic [1:0] CAUSE_STOP = 2'b10;

  // Width of a counter that must hold values 0..n-1.
  function automatic int unsigned ctr_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Next interrupt cause: stop beats end of transfer, any event beats clear.
  function automatic logic [1:0] next_cause(input logic [1:0] cur,
                                            input logic eot,
                                            input logic stp,
                                            input logic clr);
    if (stp)      return CAUSE_STOP;
    else if (eot) return CAUSE_EOT;
    else if (clr) return CAUSE_NONE;
    else          return cur;
  endfunction

  // A bus condition is only valid when SCL was already high the cycle before.
  function automatic logic bus_cond(input logic scl_lvl, input logic scl_rise,
                                    input logic sda_edge);
    return scl_lvl & ~scl_rise & sda_edge;
  endfunction

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= line_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2cst_cond.sv
module i2cst_cond (
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  import i2cst_pkg::*;

  assign start_det = bus_cond(scl_lvl, scl_rise, sda_fall);
  assign stop_det  = bus_cond(scl_lvl, scl_rise, sda_rise);
endmodule

// File: rtl/i2cst_txeng.sv
module i2cst_txeng #(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              arm,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rel_stb,
  output logic              scl_hold,
  output logic              sda_low,
  output logic              ack_seen,
  output logic              eot_evt
);
  import i2cst_pkg::*;

  localparam int CNT_W   = ctr_width(DATA_W);
  localparam int SET_W   = ctr_width(SETUP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [SET_W-1:0] SET_END  = SET_W'(SETUP_CYC);

  tx_state_e         st;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SET_W-1:0]  set_cnt;
  logic              ack_q;
  logic              bus_abort;
  logic              last_fall;
  logic              ninth_rise;

  assign bus_abort  = start_det | stop_det;
  assign last_fall  = (st == ST_SHIFT) & scl_fall & (bit_cnt == LAST_BIT);
  assign ninth_rise = (st == ST_ACK) & scl_rise & ~bus_abort;
  assign eot_evt    = (st == ST_ACK) & scl_fall & ~bus_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      set_cnt <= '0;
      ack_q   <= 1'b0;
    end else if (bus_abort) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      set_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (arm) st <= ST_HOLD;
        ST_HOLD: begin
          if (tx_wr) begin
            shreg   <= tx_data;
            bit_cnt <= '0;
            set_cnt <= '0;
            st      <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (set_cnt == SET_END) st <= ST_SHIFT;
          else                    set_cnt <= set_cnt + 1'b1;
        end
        ST_SHIFT: begin
          if (last_fall) begin
            st <= ST_ACK;
          end else if (scl_fall) begin
            shreg   <= {shreg[DATA_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (ninth_rise) ack_q <= ~sda_lvl;
          if (eot_evt)    st    <= ack_q ? ST_HOLD : ST_NACKW;
        end
        ST_NACKW: if (rel_stb) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign scl_hold = (st == ST_HOLD) | (st == ST_SETUP) | (st == ST_NACKW);
  assign sda_low  = ((st == ST_SETUP) | (st == ST_SHIFT)) & ~shreg[DATA_W-1];
  assign ack_seen = ack_q;

  p_sda_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_low));

  p_ack_slot_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_fall |=> !sda_low);

  p_ack_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ninth_rise |=> (ack_seen == !$past(sda_lvl)));

  p_eot_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eot_evt |=> scl_hold);

  p_nack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_evt && !ack_seen) |=> (!sda_low && scl_hold));

  p_start_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_low && !scl_hold));
endmodule

// File: rtl/i2cst_irq.sv
module i2cst_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eot_evt,
  input  logic       stop_evt,
  input  logic       irq_ack,
  output logic       irq,
  output logic [1:0] irq_cause
);
  import i2cst_pkg::*;

  logic [1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_NONE;
    else        cause_q <= next_cause(cause_q, eot_evt, stop_evt, irq_ack);
  end

  assign irq_cause = cause_q;
  assign irq       = |cause_q;

  p_eot_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_evt && !stop_evt) |=> (irq_cause == 2'b01));

  p_stop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (irq_cause == 2'b10));

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !eot_evt && !stop_evt) |=> (irq_cause == 2'b00));

  p_cause_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_cause));
endmodule

// File: rtl/i2cst_top.sv
module i2cst_top #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              arm,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rel_stb,
  input  logic              irq_ack,
  output logic              ack_seen,
  output logic              irq,
  output logic [1:0]        irq_cause
);
  localparam int N_LINES = 2;
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_lvl;
  logic [N_LINES-1:0] line_rise;
  logic [N_LINES-1:0] line_fall;
  logic               start_det;
  logic               stop_det;
  logic               eot_evt;

  assign line_raw[IDX_SCL] = scl_i;
  assign line_raw[IDX_SDA] = sda_i;

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      i2cst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_raw[g]),
        .lvl     (line_lvl[g]),
        .rise    (line_rise[g]),
        .fall    (line_fall[g])
      );
    end
  endgenerate

  i2cst_cond u_cond (
    .scl_lvl   (line_lvl[IDX_SCL]),
    .scl_rise  (line_rise[IDX_SCL]),
    .sda_rise  (line_rise[IDX_SDA]),
    .sda_fall  (line_fall[IDX_SDA]),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cst_txeng #(.DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (line_lvl[IDX_SCL]),
    .scl_rise  (line_rise[IDX_SCL]),
    .scl_fall  (line_fall[IDX_SCL]),
    .sda_lvl   (line_lvl[IDX_SDA]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .arm       (arm),
    .tx_wr     (tx_wr),
    .tx_data   (tx_data),
    .rel_stb   (rel_stb),
    .scl_hold  (scl_oe),
    .sda_low   (sda_oe),
    .ack_seen  (ack_seen),
    .eot_evt   (eot_evt)
  );

  i2cst_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .eot_evt   (eot_evt),
    .stop_evt  (stop_det),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .irq_cause (irq_cause)
  );

  p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2cst_top.sv
module tb_i2cst_top;
  localparam int DW    = 8;
  localparam int SYNC  = 3;
  localparam int SETUP = 6;
  localparam int HALF  = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          m_scl_low, m_sda_low;
  logic          arm, tx_wr, rel_stb, irq_ack;
  logic [DW-1:0] tx_data;
  logic          scl_oe, sda_oe, ack_seen, irq;
  logic [1:0]    irq_cause;
  int            n_chk = 0;
  int            n_fail = 0;

  wire scl_bus = ~(m_scl_low | scl_oe);
  wire sda_bus = ~(m_sda_low | sda_oe);

  i2cst_top #(.DATA_W(DW), .SYNC_STAGES(SYNC), .SETUP_CYC(SETUP)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .arm(arm), .tx_wr(tx_wr),
    .tx_data(tx_data), .rel_stb(rel_stb), .irq_ack(irq_ack),
    .ack_seen(ack_seen), .irq(irq), .irq_cause(irq_cause)
  );

  function automatic logic exp_bit(input logic [DW-1:0] d, input int k);
    return d[DW-1-k];
  endfunction

  function automatic int exp_cause(input bit stop_seen, input bit eot_seen);
    return stop_seen ? 2 : (eot_seen ? 1 : 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic p_arm();     arm = 1;     cyc(1); arm = 0;     endtask
  task automatic p_rel();     rel_stb = 1; cyc(1); rel_stb = 0; endtask
  task automatic p_irqack();  irq_ack = 1; cyc(1); irq_ack = 0; endtask
  task automatic p_write(input logic [DW-1:0] d);
    tx_data = d; tx_wr = 1; cyc(1); tx_wr = 0;
  endtask

  // Master clocks one byte out of the slave, then the ninth clock.
  task automatic xfer(input logic [DW-1:0] d, input bit mack, input int dly);
    logic s0, s1, s2;
    m_scl_low = 0;
    cyc(dly);
    chk("R1 stretch before write", int'(scl_bus), 0);
    chk("R1 sda free before write", int'(sda_oe), 0);
    p_write(d);
    for (int k = 0; k < DW; k++) begin
      wait_scl_high();
      cyc(2);  s0 = sda_bus;
      cyc(HALF/2); s1 = sda_bus;
      cyc(HALF/2 - 4); s2 = sda_bus;
      chk("R2 data bit", int'(s1), int'(exp_bit(d, k)));
      chk("R3 sda stable in high", int'(s0 == s1 && s1 == s2), 1);
      m_scl_low = 1;
      cyc(HALF/2);
      if (k == DW-1) begin
        chk("R4 sda released for ack", int'(sda_oe), 0);
        m_sda_low = mack;
      end
      cyc(HALF/2);
      m_scl_low = 0;
    end
    wait_scl_high();
    cyc(HALF/2);
    chk("R5 ack captured", int'(ack_seen), int'(mack));
    cyc(HALF/2);
    m_scl_low = 1;
    cyc(12);
    chk("R6 stretch after ninth", int'(scl_oe), 1);
    chk("R6 eot cause", int'(irq_cause), exp_cause(0, 1));
    chk("R10 irq follows cause", int'(irq), 1);
    p_irqack();
    cyc(1);
    chk("R10 ack clears", int'(irq_cause), 0);
    chk("R10 irq low", int'(irq), 0);
    if (mack) begin
      cyc(4);
      m_sda_low = 0;
      cyc(4);
    end
  endtask

  task automatic end_nack();
    m_sda_low = 1;
    cyc(4);
    p_write(DW'($urandom));
    cyc(SETUP + 10);
    chk("R7 write ignored scl", int'(scl_oe), 1);
    chk("R7 write ignored sda", int'(sda_oe), 0);
    p_rel();
    cyc(6);
    chk("R8 release after nack", int'(scl_oe), 0);
    m_scl_low = 0;
    cyc(HALF);
    m_sda_low = 0;
    cyc(12);
    chk("R9 stop cause", int'(irq_cause), exp_cause(1, 0));
    chk("R9 lines released", int'(scl_oe | sda_oe), 0);
    p_irqack();
    cyc(2);
    chk("R10 clear after stop", int'(irq), 0);
    m_scl_low = 1;
    cyc(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; m_scl_low = 0; m_sda_low = 0;
    arm = 0; tx_wr = 0; rel_stb = 0; irq_ack = 0; tx_data = '0;
    cyc(5);
    rst_n = 1;
    cyc(5);
    chk("R1 reset scl_oe", int'(scl_oe), 0);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset cause", int'(irq_cause), 0);
    chk("R5 reset ack_seen", int'(ack_seen), 0);

    // Directed: rel_stb ignored while stretching, then ack/nack bytes
    m_scl_low = 1;
    cyc(HALF);
    p_arm();
    cyc(4);
    chk("R1 arm stretches", int'(scl_oe), 1);
    p_rel();
    cyc(6);
    chk("R8 rel ignored in hold", int'(scl_oe), 1);
    xfer(8'h00, 1, 5);
    xfer(8'hFF, 1, 1);
    xfer(8'hA5, 1, 30);
    xfer(8'h5A, 0, 3);
    end_nack();

    // Constrained random transactions
    for (int t = 0; t < 20; t++) begin
      int nb;
      nb = 1 + int'($urandom % 4);
      p_arm();
      cyc(4);
      for (int b = 0; b < nb; b++)
        xfer(DW'($urandom), (b != nb - 1), 1 + int'($urandom % 40));
      end_nack();
    end

    // Directed: start in the middle of a byte
    p_arm();
    cyc(4);
    m_scl_low = 0;
    cyc(3);
    p_write(8'hFF);
    for (int k = 0; k < 3; k++) begin
      wait_scl_high();
      cyc(HALF);
      m_scl_low = 1;
      cyc(HALF);
      m_scl_low = 0;
    end
    wait_scl_high();
    cyc(HALF/2);
    m_sda_low = 1;
    cyc(12);
    chk("R11 start releases sda", int'(sda_oe), 0);
    chk("R11 start releases scl", int'(scl_oe), 0);
    chk("R11 no irq on start", int'(irq), 0);
    m_scl_low = 1;
    cyc(HALF);
    m_sda_low = 0;
    for (int k = 0; k < DW + 1; k++) begin
      cyc(HALF/2);
      m_scl_low = 0;
      cyc(HALF);
      chk("R11 no data after start", int'(sda_bus), 1);
      m_scl_low = 1;
      cyc(HALF/2);
    end
    chk("R11 no eot after start", int'(irq), 0);
    m_sda_low = 1;
    cyc(HALF);
    m_scl_low = 0;
    cyc(HALF);
    m_sda_low = 0;
    cyc(12);
    chk("R9 stop after start", int'(irq_cause), 2);
    p_irqack();
    cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule